// File: doc/BRIEF.md
# Storage Controller Register Bank

This block is the host-visible control and status register file of a storage queue controller. The host reaches it over a simple 32-bit bus that takes an address, write data, byte strobes, a request and a write flag. The bank is always ready, and a read returns its data one cycle after the request is accepted. The bank holds the identity registers, the controller configuration, the admin queue setup and a small doorbell window. It drives the resulting fields straight to the queue engine.

The interrupt mask is a single internal vector with two addresses. Writing ones to the set address masks vectors, and writing ones to the clear address unmasks them. Both addresses read back the live mask. While the core signals that the message-table interrupt mode is active, both addresses ignore writes and read as zero. Some registers read as zero and ignore writes depending on other state: the buffer location register is gated by the buffer size, and the subsystem reset address is gated by a capability bit. The reserved ranges and misaligned accesses do the same.

Top module: `stor_reg_bank`

## Requirements
- R1: After reset, the interrupt mask, every writable register and every doorbell are zero, no read data is valid, and `rdy_o` is high.
- R2: A read accepted in one cycle has `rvalid_o` high and its data on `rdata_o` in the next cycle only. When no read is accepted, `rvalid_o` is low in the following cycle.
- R3: The capabilities value is read-only and is reached as two words: the low half at 000h and the high half at 004h. The version at 008h is read-only and holds the major number in bits 31:16 and the minor number in bits 15:8.
- R4: A write to 00Ch sets every mask bit whose written bit is 1 in an enabled byte lane. All other bits are unchanged.
- R5: A write to 010h clears every mask bit whose written bit is 1 in an enabled byte lane. All other bits are unchanged.
- R6: A read of 00Ch or 010h returns the live mask. While `msix_i` is high, writes to both addresses are ignored and both read as zero.
- R7: The following registers are read/write with byte strobes and drive their outputs: configuration at 014h (bit 0 is the enable), admin queue attributes at 024h, admin submission base at 028h/02Ch, and admin completion base at 030h/034h. Each 64-bit base has its low half at the lower address.
- R8: Status at 01Ch reads `status_i`. A write to it has no effect.
- R9: Offset 018h, the range 040h–EFCh and the range F00h–FFCh read as zero and ignore writes.
- R10: Buffer size at 03Ch reads `cmb_sz_i`. While that value is zero, buffer location at 038h reads zero, ignores writes and drives `cmb_loc_o` to zero.
- R11: When capability bit 36 is set, a full-word write of `SSR_KEY` to 020h raises `ssr_o` for exactly the next cycle. When that bit is clear, 020h behaves as reserved. Address 020h always reads zero.
- R12: Doorbell i sits at 1000h + 4·i and holds `DB_W` bits. Doorbells are writable and readable and drive slice i of `db_o`. Doorbell 0 is the admin submission tail. Addresses past the last doorbell read zero and ignore writes.
- R13: An access whose address bits 1:0 are not zero writes nothing and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte strobes |
| rdy_o | output | 1 | Access accepted (always high) |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |
| msix_i | input | 1 | Message-table interrupt mode active |
| status_i | input | 32 | Controller status from the core |
| cmb_sz_i | input | 32 | Memory buffer size from the core |
| irq_mask_o | output | MASK_W | Live interrupt mask |
| cfg_o | output | 32 | Configuration register |
| cfg_en_o | output | 1 | Controller enable |
| aqa_o | output | 32 | Admin queue attributes |
| asq_o | output | 64 | Admin submission queue base |
| acq_o | output | 64 | Admin completion queue base |
| cmb_loc_o | output | 32 | Memory buffer location (zero while size is zero) |
| ssr_o | output | 1 | Subsystem reset pulse |
| db_o | output | DB_NUM*DB_W | Doorbell values, entry 0 in the low bits |

## Verification
A corrupted mask shows up on `irq_mask_o` in the cycle after the write that produced it. It also shows up on the next read of either alias, one cycle after that read is accepted. A wrong decode leaves a configuration, queue or doorbell output changed, or left unchanged, one cycle after the write. The gated cases are the misaligned accesses, the reserved ranges, the zero buffer size and the missing reset capability. Errors there appear as a nonzero read or an output that moved when it should have held. A wrong reset trigger shows as `ssr_o` being high, or low, in the single cycle after the key write.

// File: rtl/stor_reg_pkg.sv
package stor_reg_pkg;
  localparam logic [11:0] OFF_CAP_LO = 12'h000;
  localparam logic [11:0] OFF_CAP_HI = 12'h004;
  localparam logic [11:0] OFF_VER    = 12'h008;
  localparam logic [11:0] OFF_MSET   = 12'h00C;
  localparam logic [11:0] OFF_MCLR   = 12'h010;
  localparam logic [11:0] OFF_CFG    = 12'h014;
  localparam logic [11:0] OFF_STS    = 12'h01C;
  localparam logic [11:0] OFF_SSR    = 12'h020;
  localparam logic [11:0] OFF_AQA    = 12'h024;
  localparam logic [11:0] OFF_ASQ_LO = 12'h028;
  localparam logic [11:0] OFF_ASQ_HI = 12'h02C;
  localparam logic [11:0] OFF_ACQ_LO = 12'h030;
  localparam logic [11:0] OFF_ACQ_HI = 12'h034;
  localparam logic [11:0] OFF_LOC    = 12'h038;
  localparam logic [11:0] OFF_SZ     = 12'h03C;
  localparam int          SSR_BIT    = 36;
  localparam int          DB_BASE    = 4096;

  function automatic logic [31:0] be_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction
endpackage

// File: rtl/stor_rw_reg.sv
module stor_rw_reg #(
  parameter int W = 32,
  localparam int BW = (W + 7) / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [BW-1:0] be_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  q_o
);
  logic [W-1:0] m;

  always_comb begin
    for (int i = 0; i < W; i++) m[i] = be_i[i/8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= (q_o & ~m) | (wdata_i & m);
  end
endmodule

// File: rtl/stor_irq_mask.sv
module stor_irq_mask #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_o <= '0;
    else if (set_i) mask_o <= mask_o | bits_i;
    else if (clr_i) mask_o <= mask_o & ~bits_i;
  end
endmodule

// File: rtl/stor_db_bank.sv
module stor_db_bank #(
  parameter int NUM = 4,
  parameter int W   = 16,
  localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1,
  localparam int BW    = (W + 7) / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [BW-1:0]    be_i,
  input  logic [W-1:0]     wdata_i,
  output logic [NUM*W-1:0] db_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_db
    stor_rw_reg #(.W(W)) u_db (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we_i && (idx_i == IDX_W'(g))),
      .be_i    (be_i),
      .wdata_i (wdata_i),
      .q_o     (db_o[g*W +: W])
    );
  end
endmodule

// File: rtl/stor_reg_bank.sv
module stor_reg_bank
  import stor_reg_pkg::*;
#(
  parameter int          ADDR_W  = 13,
  parameter int          MASK_W  = 32,
  parameter int          DB_NUM  = 4,
  parameter int          DB_W    = 16,
  parameter logic [63:0] CAP_VAL = 64'h0000_0010_0000_00FF,
  parameter logic [15:0] VER_MAJ = 16'd1,
  parameter logic [7:0]  VER_MIN = 8'd2,
  parameter logic [31:0] SSR_KEY = 32'h5EED_C0DE,
  localparam int DB_IDX_W = (DB_NUM > 1) ? $clog2(DB_NUM) : 1,
  localparam int DB_BW    = (DB_W + 7) / 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [31:0]            wdata_i,
  input  logic [3:0]             be_i,
  output logic                   rdy_o,
  output logic                   rvalid_o,
  output logic [31:0]            rdata_o,
  input  logic                   msix_i,
  input  logic [31:0]            status_i,
  input  logic [31:0]            cmb_sz_i,
  output logic [MASK_W-1:0]      irq_mask_o,
  output logic [31:0]            cfg_o,
  output logic                   cfg_en_o,
  output logic [31:0]            aqa_o,
  output logic [63:0]            asq_o,
  output logic [63:0]            acq_o,
  output logic [31:0]            cmb_loc_o,
  output logic                   ssr_o,
  output logic [DB_NUM*DB_W-1:0] db_o
);
  localparam logic [31:0] VER_WORD = {VER_MAJ, VER_MIN, 8'h00};
  localparam bit          SSR_SUP  = CAP_VAL[SSR_BIT];

  logic              aligned, in_regs, in_db, wr, rd, loc_en;
  logic [11:0]       off;
  logic [ADDR_W-1:0] db_off;
  logic [ADDR_W-3:0] db_word;
  logic [31:0]       wmask, rd_val, loc_q;
  logic [31:0]       asq_lo, asq_hi, acq_lo, acq_hi;
  logic              ssr_q, rvalid_q;
  logic [31:0]       rdata_q;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign in_regs = (32'(addr_i) < DB_BASE);
  assign off     = addr_i[11:0];
  assign db_off  = addr_i - ADDR_W'(DB_BASE);
  assign db_word = db_off[ADDR_W-1:2];
  assign in_db   = !in_regs && (32'(db_word) < DB_NUM);
  assign wr      = req_i && we_i && aligned;
  assign rd      = req_i && !we_i;
  assign loc_en  = (cmb_sz_i != '0);
  assign wmask   = wdata_i & be_mask(be_i);

  stor_irq_mask #(.W(MASK_W)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wr && in_regs && off == OFF_MSET && !msix_i),
    .clr_i  (wr && in_regs && off == OFF_MCLR && !msix_i),
    .bits_i (wmask[MASK_W-1:0]),
    .mask_o (irq_mask_o)
  );

  stor_rw_reg u_cfg (.clk_i, .rst_ni, .we_i(wr && in_regs && off == OFF_CFG),
                     .be_i, .wdata_i, .q_o(cfg_o));
  stor_rw_reg u_aqa (.clk_i, .rst_ni, .we_i(wr && in_regs && off == OFF_AQA),
                     .be_i, .wdata_i, .q_o(aqa_o));
  stor_rw_reg u_asq_lo (.clk_i, .rst_ni, .we_i(wr && in_regs && off == OFF_ASQ_LO),
                        .be_i, .wdata_i, .q_o(asq_lo));
  stor_rw_reg u_asq_hi (.clk_i, .rst_ni, .we_i(wr && in_regs && off == OFF_ASQ_HI),
                        .be_i, .wdata_i, .q_o(asq_hi));
  stor_rw_reg u_acq_lo (.clk_i, .rst_ni, .we_i(wr && in_regs && off == OFF_ACQ_LO),
                        .be_i, .wdata_i, .q_o(acq_lo));
  stor_rw_reg u_acq_hi (.clk_i, .rst_ni, .we_i(wr && in_regs && off == OFF_ACQ_HI),
                        .be_i, .wdata_i, .q_o(acq_hi));
  stor_rw_reg u_loc (.clk_i, .rst_ni, .we_i(wr && in_regs && off == OFF_LOC && loc_en),
                     .be_i, .wdata_i, .q_o(loc_q));

  stor_db_bank #(.NUM(DB_NUM), .W(DB_W)) u_db (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr && in_db),
    .idx_i   (db_word[DB_IDX_W-1:0]),
    .be_i    (be_i[DB_BW-1:0]),
    .wdata_i (wdata_i[DB_W-1:0]),
    .db_o    (db_o)
  );

  assign cfg_en_o  = cfg_o[0];
  assign asq_o     = {asq_hi, asq_lo};
  assign acq_o     = {acq_hi, acq_lo};
  assign cmb_loc_o = loc_en ? loc_q : '0;
  assign rdy_o     = 1'b1;

  always_comb begin
    rd_val = '0;
    if (aligned && in_regs) begin
      unique case (off)
        OFF_CAP_LO: rd_val = CAP_VAL[31:0];
        OFF_CAP_HI: rd_val = CAP_VAL[63:32];
        OFF_VER:    rd_val = VER_WORD;
        OFF_MSET,
        OFF_MCLR:   rd_val = msix_i ? '0 : 32'(irq_mask_o);
        OFF_CFG:    rd_val = cfg_o;
        OFF_STS:    rd_val = status_i;
        OFF_AQA:    rd_val = aqa_o;
        OFF_ASQ_LO: rd_val = asq_lo;
        OFF_ASQ_HI: rd_val = asq_hi;
        OFF_ACQ_LO: rd_val = acq_lo;
        OFF_ACQ_HI: rd_val = acq_hi;
        OFF_LOC:    rd_val = cmb_loc_o;
        OFF_SZ:     rd_val = cmb_sz_i;
        default:    rd_val = '0;
      endcase
    end else if (aligned && in_db) begin
      rd_val = 32'(db_o[32'(db_word[DB_IDX_W-1:0])*DB_W +: DB_W]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      ssr_q    <= 1'b0;
    end else begin
      rvalid_q <= rd;
      rdata_q  <= rd ? rd_val : '0;
      ssr_q    <= SSR_SUP && wr && in_regs && off == OFF_SSR &&
                  be_i == 4'hF && wdata_i == SSR_KEY;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
  assign ssr_o    = ssr_q;
endmodule

// File: rtl/stor_reg_bank_chk.sv
module stor_reg_bank_chk
  import stor_reg_pkg::*;
#(
  parameter int          ADDR_W  = 13,
  parameter int          MASK_W  = 32,
  parameter logic [63:0] CAP_VAL = 64'h0,
  parameter logic [31:0] SSR_KEY = 32'h0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [3:0]        be_i,
  input logic              rvalid_o,
  input logic [31:0]       rdata_o,
  input logic              msix_i,
  input logic [MASK_W-1:0] irq_mask_o,
  input logic              ssr_o
);
  logic [MASK_W-1:0] bits;
  logic              acc_set, acc_clr, rsv_rd;
  assign bits    = MASK_W'(wdata_i & be_mask(be_i));
  assign acc_set = req_i && we_i && !msix_i && 32'(addr_i) == 32'h00C;
  assign acc_clr = req_i && we_i && !msix_i && 32'(addr_i) == 32'h010;
  assign rsv_rd  = req_i && !we_i && (32'(addr_i) == 32'h018 ||
                   (32'(addr_i) >= 32'h040 && 32'(addr_i) < 32'h1000) ||
                   addr_i[1:0] != 2'b00);

  p_rd_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
  p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);
  p_mask_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_set |=> irq_mask_o == ($past(irq_mask_o) | $past(bits)));
  p_mask_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_clr |=> irq_mask_o == ($past(irq_mask_o) & ~$past(bits)));
  p_msix_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msix_i |=> $stable(irq_mask_o));
  p_reserved_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsv_rd |=> rdata_o == '0);
  p_ssr_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && 32'(addr_i) == 32'h020 && be_i == 4'hF &&
     wdata_i == SSR_KEY && CAP_VAL[SSR_BIT]) |=> ssr_o);
  p_ssr_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ssr_o |=> !ssr_o);
endmodule

bind stor_reg_bank stor_reg_bank_chk #(
  .ADDR_W(ADDR_W), .MASK_W(MASK_W), .CAP_VAL(CAP_VAL), .SSR_KEY(SSR_KEY)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .be_i(be_i), .rvalid_o(rvalid_o), .rdata_o(rdata_o),
  .msix_i(msix_i), .irq_mask_o(irq_mask_o), .ssr_o(ssr_o)
);

// File: tb/tb_stor_reg_bank.sv
module tb_stor_reg_bank;
  localparam logic [31:0] KEY = 32'h5EED_C0DE;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, msix_i = 1'b0;
  logic [12:0] addr_i = '0;
  logic [31:0] wdata_i = '0, status_i = '0, cmb_sz_i = '0;
  logic [3:0]  be_i = '0;
  logic        rdy_o, rvalid_o, cfg_en_o, ssr_o, rvalid_b, ssr_b, rdy_b, en_b;
  logic [31:0] rdata_o, irq_mask_o, cfg_o, aqa_o, cmb_loc_o;
  logic [31:0] rdata_b, mask_b, cfg_b, aqa_b, loc_b;
  logic [63:0] asq_o, acq_o, asq_b, acq_b, db_o, db_b;
  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] rv, rvb;
  logic        vld;

  always #4 clk_i = ~clk_i;

  stor_reg_bank dut (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .be_i, .rdy_o, .rvalid_o,
    .rdata_o, .msix_i, .status_i, .cmb_sz_i, .irq_mask_o, .cfg_o, .cfg_en_o,
    .aqa_o, .asq_o, .acq_o, .cmb_loc_o, .ssr_o, .db_o);

  stor_reg_bank #(.CAP_VAL(64'h0000_0000_0000_00FF)) dut_b (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .be_i, .rdy_o(rdy_b),
    .rvalid_o(rvalid_b), .rdata_o(rdata_b), .msix_i, .status_i, .cmb_sz_i,
    .irq_mask_o(mask_b), .cfg_o(cfg_b), .cfg_en_o(en_b), .aqa_o(aqa_b),
    .asq_o(asq_b), .acq_o(acq_b), .cmb_loc_o(loc_b), .ssr_o(ssr_b), .db_o(db_b));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d, input logic [3:0] b = 4'hF);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d; be_i = b;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 0; we_i = 0;
  endtask

  task automatic rd(input logic [12:0] a);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = a;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 0;
    rv = rdata_o; rvb = rdata_b; vld = rvalid_o;
  endtask

  task automatic t_reset;
    chk("R1 mask", irq_mask_o, 0);
    chk("R1 cfg", {cfg_o, aqa_o}, 0);
    chk("R1 queues", asq_o | acq_o, 0);
    chk("R1 db", db_o, 0);
    chk("R1 rvalid/rdy", {rvalid_o, rdy_o}, 2'b01);
  endtask

  task automatic t_latency;
    rd(13'h008);
    chk("R2 rvalid after read", vld, 1);
    @(negedge clk_i);
    chk("R2 rvalid drops", rvalid_o, 0);
  endtask

  task automatic t_ident;
    rd(13'h000); chk("R3 cap lo", rv, 32'h0000_00FF);
    rd(13'h004); chk("R3 cap hi", rv, 32'h0000_0010);
    rd(13'h008); chk("R3 version", rv, 32'h0001_0200);
    wr(13'h000, 32'hFFFF_FFFF);
    rd(13'h000); chk("R3 cap read-only", rv, 32'h0000_00FF);
  endtask

  task automatic t_mask;
    wr(13'h00C, 32'h0000_00F0);
    chk("R4 set", irq_mask_o, 32'h0000_00F0);
    wr(13'h00C, 32'hFFFF_0000, 4'b0100);
    chk("R4 set lane", irq_mask_o, 32'h00FF_00F0);
    wr(13'h010, 32'h0000_0030);
    chk("R5 clear", irq_mask_o, 32'h00FF_00C0);
    wr(13'h010, 32'h0);
    chk("R5 zero no effect", irq_mask_o, 32'h00FF_00C0);
    rd(13'h00C); chk("R6 read set alias", rv, 32'h00FF_00C0);
    rd(13'h010); chk("R6 read clear alias", rv, 32'h00FF_00C0);
  endtask

  task automatic t_msix;
    msix_i = 1;
    wr(13'h00C, 32'hFFFF_FFFF);
    wr(13'h010, 32'hFFFF_FFFF);
    chk("R6 msix writes ignored", irq_mask_o, 32'h00FF_00C0);
    rd(13'h00C); chk("R6 msix reads zero", rv, 0);
    msix_i = 0;
    rd(13'h010); chk("R6 after msix", rv, 32'h00FF_00C0);
  endtask

  task automatic t_cfg;
    wr(13'h014, 32'h0046_0001);
    chk("R7 cfg", {cfg_o, 31'b0, cfg_en_o}, {32'h0046_0001, 32'h1});
    wr(13'h014, 32'hFFFF_FFAA, 4'b0001);
    chk("R7 cfg byte lane", {cfg_o, 31'b0, cfg_en_o}, {32'h0046_00AA, 32'h0});
    wr(13'h024, 32'h001F_001F);
    wr(13'h028, 32'h0000_1000); wr(13'h02C, 32'h1);
    wr(13'h030, 32'h0000_2000); wr(13'h034, 32'h2);
    chk("R7 aqa", aqa_o, 32'h001F_001F);
    chk("R7 asq", asq_o, 64'h1_0000_1000);
    chk("R7 acq", acq_o, 64'h2_0000_2000);
    rd(13'h02C); chk("R7 asq hi read", rv, 32'h1);
  endtask

  task automatic t_status;
    status_i = 32'h5;
    rd(13'h01C); chk("R8 status", rv, 32'h5);
    wr(13'h01C, 32'hFFFF);
    rd(13'h01C); chk("R8 status write no effect", rv, 32'h5);
  endtask

  task automatic t_reserved;
    foreach (rsv[i]) wr(rsv[i], 32'hFFFF_FFFF);
    chk("R9 writes ignored", {cfg_o, aqa_o, irq_mask_o}, {32'h0046_00AA, 32'h001F_001F, 32'h00FF_00C0});
    foreach (rsv[i]) begin
      rd(rsv[i]); chk("R9 reads zero", rv, 0);
    end
  endtask
  logic [12:0] rsv [5] = '{13'h018, 13'h040, 13'hEFC, 13'hF00, 13'hFFC};

  task automatic t_loc;
    cmb_sz_i = 0;
    wr(13'h038, 32'h1234);
    chk("R10 loc ignored", cmb_loc_o, 0);
    rd(13'h038); chk("R10 loc reads zero", rv, 0);
    cmb_sz_i = 32'h100;
    rd(13'h03C); chk("R10 size", rv, 32'h100);
    wr(13'h038, 32'h1234);
    rd(13'h038); chk("R10 loc stored", {rv, cmb_loc_o}, {32'h1234, 32'h1234});
    cmb_sz_i = 0;
    rd(13'h038); chk("R10 loc gated", {rv, cmb_loc_o}, 0);
  endtask

  task automatic t_ssr;
    wr(13'h020, KEY);
    chk("R11 pulse supported", {ssr_o, ssr_b}, 2'b10);
    @(negedge clk_i);
    chk("R11 pulse one cycle", ssr_o, 0);
    wr(13'h020, KEY ^ 32'h1);
    chk("R11 wrong key", ssr_o, 0);
    wr(13'h020, KEY, 4'b0111);
    chk("R11 partial write", ssr_o, 0);
    rd(13'h020); chk("R11 reads zero", {rv, rvb}, 0);
  endtask

  task automatic t_db;
    wr(13'h1000, 32'hDEAD_0005);
    wr(13'h100C, 32'h0000_0007);
    chk("R12 doorbells", db_o, 64'h0007_0000_0000_0005);
    rd(13'h1000); chk("R12 admin tail read", rv, 32'h5);
    wr(13'h1010, 32'hFFFF_FFFF);
    chk("R12 beyond last ignored", db_o, 64'h0007_0000_0000_0005);
    rd(13'h1010); chk("R12 beyond last reads zero", rv, 0);
  endtask

  task automatic t_unaligned;
    wr(13'h016, 32'hFFFF_FFFF);
    chk("R13 unaligned write", cfg_o, 32'h0046_00AA);
    wr(13'h00D, 32'hFFFF_FFFF);
    chk("R13 unaligned mask", irq_mask_o, 32'h00FF_00C0);
    rd(13'h009); chk("R13 unaligned read", rv, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1;
    t_latency; t_ident; t_mask; t_msix; t_cfg; t_status;
    t_reserved; t_loc; t_ssr; t_db; t_unaligned;
    repeat (2) @(negedge clk_i);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule